// File: doc/BRIEF.md
# PCIe Root Port Link Bring-Up Sequencer

This block is a hardware sequencer that prepares a PCIe root port once reset is released. A pulse on `start` makes it sample the controller's global status word. If the link is not trained yet, it switches link training off before it changes anything. It then programs the controller through a single register access port: device type, the cache attributes for master reads and writes, the target speed in two places, and one equalization control bit. Next it switches training back on if the link is still down. Finally it polls for link-up within a bounded time window.

When both link indications are seen, the sequencer waits a fixed settling time and then reports link up. If the window expires first, it reports link down. Every field update that must keep the neighbouring bits is a read-modify-write. Only one register access is in flight at any time. The time bases are derived from a clock-frequency parameter, so a bench can shorten them.

Top module: `pcie_link_seq`

## Requirements
- R1: After reset, `done`, `link_up` and `reg_req` are 0. A `start` pulse while idle clears `done` and `link_up` in the next cycle. Both outputs then keep their final values until the next `start`.
- R2: The link counts as up only when bit 1 and bit 9 of the global status word (address 0x8008) are both 1 in the same read. Either bit alone counts as down.
- R3: If the first status read shows the link down, the first write of the run goes to global control (address 0x8000) and clears bit 2, the training enable, while every other bit keeps its value. If that read shows the link up, no write changes bit 2.
- R4: Bits 7:4 of global control are set to 4 (root complex). All other bits keep their values.
- R5: Address 0x8050 is written with 0x0000_3511 and address 0x8054 is written with 0x0000_5311.
- R6: Bits 3:0 of address 0x00A0 and bits 3:0 of address 0x007C are replaced by `target_speed` as sampled at `start`. The other bits keep their values.
- R7: Bit 5 of address 0x08A8 is set. The other bits keep their values.
- R8: The writes follow a fixed order: the optional training-off write, then global control type, 0x8050, 0x8054, 0x00A0, 0x007C, 0x08A8, then the optional training-on write.
- R9: After configuration the status is read again. Only if it shows the link down, bit 2 of global control is set and the other bits keep their values.
- R10: Polling goes on until TIMEOUT_US microseconds have passed. If the link has not been seen up by then, the run ends with `done`=1 and `link_up`=0.
- R11: Once a poll sees the link up, the block waits SETTLE_US microseconds and then ends with `done`=1 and `link_up`=1.
- R12: Only one access is outstanding. `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` are held until `reg_ack`. A read-modify-write issues its read and then its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one bring-up run when idle |
| target_speed | input | 4 | Requested speed code (1..3) |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | Register byte address |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | One-cycle completion strobe for the current access |
| reg_rdata | input | 32 | Read data, valid with `reg_ack` |
| done | output | 1 | Run finished; held until the next start |
| link_up | output | 1 | Outcome of the finished run |

## Verification
The assertions assume that the controller answers each request with exactly one single-cycle `reg_ack` and never raises `reg_ack` while no request is pending. They also assume that `target_speed` does not matter after it has been sampled. The bench's responder acknowledges only a pending request, with a latency that rotates between one and three cycles. It then drops `reg_ack` for at least one cycle before it serves the next request. The link model in the bench changes the status bits only as a function of the training-enable bit that was written and of elapsed time. This gives already-up, trains-later, never-up and single-bit cases.

// File: rtl/plseq_pkg.sv
package plseq_pkg;

    localparam int REG_AW = 16;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] A_GCTRL   = 16'h8000;
    localparam logic [REG_AW-1:0] A_GSTAT   = 16'h8008;
    localparam logic [REG_AW-1:0] A_RDCACHE = 16'h8050;
    localparam logic [REG_AW-1:0] A_WRCACHE = 16'h8054;
    localparam logic [REG_AW-1:0] A_LNKCTL2 = 16'h00A0;
    localparam logic [REG_AW-1:0] A_LNKCAP  = 16'h007C;
    localparam logic [REG_AW-1:0] A_EQCTRL  = 16'h08A8;

    localparam int BIT_DLL_UP  = 1;
    localparam int BIT_PHY_UP  = 9;
    localparam int BIT_TRAIN   = 2;
    localparam int BIT_EQ_FAST = 5;

    localparam logic [REG_DW-1:0] TYPE_FIELD   = 32'h0000_00F0;
    localparam logic [REG_DW-1:0] TYPE_ROOT    = 32'h0000_0040;
    localparam logic [REG_DW-1:0] SPEED_FIELD  = 32'h0000_000F;
    localparam logic [REG_DW-1:0] RD_ATTR_VAL  = 32'h0000_3511;
    localparam logic [REG_DW-1:0] WR_ATTR_VAL  = 32'h0000_5311;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_RMW = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] keep;
        logic [REG_DW-1:0] set;
    } acc_cmd_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STAT0,
        S_TRN_OFF,
        S_DEVTYPE,
        S_RDC,
        S_WRC,
        S_SPD_CTL,
        S_SPD_CAP,
        S_EQ,
        S_STAT1,
        S_TRN_ON,
        S_POLL,
        S_SETTLE
    } seq_state_e;

    function automatic logic link_ok(input logic [REG_DW-1:0] s);
        return s[BIT_DLL_UP] & s[BIT_PHY_UP];
    endfunction

    function automatic logic [REG_DW-1:0] merge(input logic [REG_DW-1:0] old,
                                                input logic [REG_DW-1:0] keep,
                                                input logic [REG_DW-1:0] set);
        return (old & keep) | set;
    endfunction

endpackage

// File: rtl/plseq_timer.sv
module plseq_timer
    import plseq_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int US_W   = 17
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            run,
    output logic [US_W-1:0] us_cnt
);
    localparam int RAW_CPU = CLK_HZ / 1_000_000;
    localparam int CPU     = (RAW_CPU < 1) ? 1 : RAW_CPU;
    localparam int PW      = (CPU < 2) ? 1 : $clog2(CPU);

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre    <= '0;
            us_cnt <= '0;
        end else if (run) begin
            if (pre == PW'(CPU - 1)) begin
                pre <= '0;
                if (us_cnt != '1) us_cnt <= us_cnt + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    // R10
    tick_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !clr) |=> (us_cnt >= $past(us_cnt)));

endmodule

// File: rtl/plseq_access.sv
module plseq_access
    import plseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  acc_cmd_t          cmd,
    output logic              fin,
    output logic [REG_DW-1:0] rd_q,
    output logic              reg_req,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [REG_DW-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [REG_DW-1:0] reg_rdata
);
    typedef enum logic [1:0] {E_IDLE, E_RD, E_WR} eng_e;

    eng_e      est;
    acc_cmd_t  cur;

    assign reg_req = (est == E_RD) || (est == E_WR);
    assign reg_we  = (est == E_WR);
    assign reg_addr = cur.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            est       <= E_IDLE;
            cur       <= '{op: OP_RD, addr: '0, keep: '0, set: '0};
            fin       <= 1'b0;
            rd_q      <= '0;
            reg_wdata <= '0;
        end else begin
            fin <= 1'b0;
            unique case (est)
                E_IDLE: if (cmd_valid) begin
                    cur <= cmd;
                    if (cmd.op == OP_WR) begin
                        reg_wdata <= cmd.set;
                        est       <= E_WR;
                    end else begin
                        est <= E_RD;
                    end
                end
                E_RD: if (reg_ack) begin
                    rd_q <= reg_rdata;
                    if (cur.op == OP_RMW) begin
                        reg_wdata <= merge(reg_rdata, cur.keep, cur.set);
                        est       <= E_WR;
                    end else begin
                        fin <= 1'b1;
                        est <= E_IDLE;
                    end
                end
                E_WR: if (reg_ack) begin
                    fin <= 1'b1;
                    est <= E_IDLE;
                end
                default: est <= E_IDLE;
            endcase
        end
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

    // R12
    rmw_order_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_we && reg_ack && cur.op == OP_RMW) |=> (reg_req && reg_we));

endmodule

// File: rtl/pcie_link_seq.sv
module pcie_link_seq
    import plseq_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int TIMEOUT_US = 100_000,
    parameter int SETTLE_US  = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  target_speed,
    output logic        reg_req,
    output logic        reg_we,
    output logic [15:0] reg_addr,
    output logic [31:0] reg_wdata,
    input  logic        reg_ack,
    input  logic [31:0] reg_rdata,
    output logic        done,
    output logic        link_up
);
    localparam int US_MAX = (TIMEOUT_US > SETTLE_US) ? TIMEOUT_US : SETTLE_US;
    localparam int US_W   = $clog2(US_MAX + 2);
    localparam logic [US_W-1:0] TMO_L = US_W'(TIMEOUT_US);
    localparam logic [US_W-1:0] STL_L = US_W'(SETTLE_US);

    seq_state_e        state;
    logic              issued;
    logic [3:0]        speed_q;
    logic              tmr_clr;
    logic              tmr_run;
    logic [US_W-1:0]   us_cnt;
    logic              fin;
    logic [REG_DW-1:0] rd_q;
    logic              is_op;
    logic              cmd_valid;
    acc_cmd_t          cmd;

    always_comb begin
        cmd   = '{op: OP_RD, addr: A_GSTAT, keep: '1, set: '0};
        is_op = 1'b1;
        unique case (state)
            S_STAT0, S_STAT1, S_POLL: cmd = '{op: OP_RD, addr: A_GSTAT, keep: '1, set: '0};
            S_TRN_OFF: cmd = '{op: OP_RMW, addr: A_GCTRL, keep: ~(32'h1 << BIT_TRAIN), set: '0};
            S_DEVTYPE: cmd = '{op: OP_RMW, addr: A_GCTRL, keep: ~TYPE_FIELD, set: TYPE_ROOT};
            S_RDC:     cmd = '{op: OP_WR, addr: A_RDCACHE, keep: '0, set: RD_ATTR_VAL};
            S_WRC:     cmd = '{op: OP_WR, addr: A_WRCACHE, keep: '0, set: WR_ATTR_VAL};
            S_SPD_CTL: cmd = '{op: OP_RMW, addr: A_LNKCTL2, keep: ~SPEED_FIELD, set: {28'b0, speed_q}};
            S_SPD_CAP: cmd = '{op: OP_RMW, addr: A_LNKCAP, keep: ~SPEED_FIELD, set: {28'b0, speed_q}};
            S_EQ:      cmd = '{op: OP_RMW, addr: A_EQCTRL, keep: '1, set: 32'h1 << BIT_EQ_FAST};
            S_TRN_ON:  cmd = '{op: OP_RMW, addr: A_GCTRL, keep: '1, set: 32'h1 << BIT_TRAIN};
            default:   is_op = 1'b0;
        endcase
    end

    assign cmd_valid = is_op && !issued;
    assign tmr_run   = (state == S_POLL) || (state == S_SETTLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            issued  <= 1'b0;
            speed_q <= '0;
            tmr_clr <= 1'b0;
            done    <= 1'b0;
            link_up <= 1'b0;
        end else begin
            tmr_clr <= 1'b0;
            if (cmd_valid) issued <= 1'b1;
            if (fin) issued <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    speed_q <= target_speed;
                    done    <= 1'b0;
                    link_up <= 1'b0;
                    state   <= S_STAT0;
                end
                S_STAT0:   if (fin) state <= link_ok(rd_q) ? S_DEVTYPE : S_TRN_OFF;
                S_TRN_OFF: if (fin) state <= S_DEVTYPE;
                S_DEVTYPE: if (fin) state <= S_RDC;
                S_RDC:     if (fin) state <= S_WRC;
                S_WRC:     if (fin) state <= S_SPD_CTL;
                S_SPD_CTL: if (fin) state <= S_SPD_CAP;
                S_SPD_CAP: if (fin) state <= S_EQ;
                S_EQ:      if (fin) state <= S_STAT1;
                S_STAT1: if (fin) begin
                    if (link_ok(rd_q)) begin
                        state   <= S_POLL;
                        tmr_clr <= 1'b1;
                    end else begin
                        state <= S_TRN_ON;
                    end
                end
                S_TRN_ON: if (fin) begin
                    state   <= S_POLL;
                    tmr_clr <= 1'b1;
                end
                S_POLL: if (fin) begin
                    if (link_ok(rd_q)) begin
                        state   <= S_SETTLE;
                        tmr_clr <= 1'b1;
                    end else if (us_cnt >= TMO_L) begin
                        state   <= S_IDLE;
                        done    <= 1'b1;
                        link_up <= 1'b0;
                    end
                end
                S_SETTLE: if (!tmr_clr && us_cnt >= STL_L) begin
                    state   <= S_IDLE;
                    done    <= 1'b1;
                    link_up <= 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    plseq_timer #(.CLK_HZ(CLK_HZ), .US_W(US_W)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (tmr_clr),
        .run    (tmr_run),
        .us_cnt (us_cnt)
    );

    plseq_access i_access (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .fin       (fin),
        .rd_q      (rd_q),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_ack   (reg_ack),
        .reg_rdata (reg_rdata)
    );

    // R1
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(link_up)));

    // R1
    up_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        link_up |-> done);

    // R5
    rd_attr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we && reg_addr == A_RDCACHE) |-> (reg_wdata == RD_ATTR_VAL));

    // R6
    speed_field_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && reg_we && (reg_addr == A_LNKCTL2 || reg_addr == A_LNKCAP))
            |-> (reg_wdata[3:0] == speed_q));

endmodule

// File: tb/test_pcie_link_seq.sv
module test_pcie_link_seq;
    localparam int CLK_HZ  = 2_000_000;
    localparam int CPU     = 2;
    localparam int TMO_US  = 300;
    localparam int STL_US  = 20;
    localparam int TRAIN_DLY = 20;

    localparam logic [15:0] GCTRL = 16'h8000, GSTAT = 16'h8008, RDC = 16'h8050,
                            WRC = 16'h8054, LC2 = 16'h00A0, CAP = 16'h007C, EQ = 16'h08A8;

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic [3:0] target_speed = 4'd3;
    logic reg_req, reg_we, reg_ack = 0, done, link_up;
    logic [15:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata = '0;

    always #5ns clk = ~clk;

    pcie_link_seq #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(TMO_US), .SETTLE_US(STL_US)) i_pcie_link_seq (
        .clk(clk), .rst(rst), .start(start), .target_speed(target_speed),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata), .done(done), .link_up(link_up));

    int compared = 0, mismatched = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // register model
    logic [31:0] m_ctrl, m_lc2, m_cap, m_eq, m_rdc, m_wrc;
    int mode;         // 0 up, 1 up after training, 2 never, 3 bit1 only, 4 bit9 only
    logic trn_on;
    int trn_t;
    int t_up;
    int nacc;
    int cnt;
    logic [15:0] log_a [0:31];
    logic [31:0] log_d [0:31];
    int nlog;

    function automatic logic [31:0] status_val();
        logic [31:0] s = 32'h0000_0010;
        case (mode)
            0: s = s | 32'h0000_0202;
            1: if (trn_on && (cyc - trn_t) >= TRAIN_DLY) s = s | 32'h0000_0202;
            3: s = s | 32'h0000_0002;
            4: s = s | 32'h0000_0200;
            default: ;
        endcase
        return s;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            reg_ack = 0; cnt = 0;
        end else if (reg_ack) begin
            reg_ack = 0;
        end else if (reg_req) begin
            if (cnt >= (nacc % 3)) begin
                cnt = 0; nacc++;
                if (reg_we) begin
                    if (nlog < 32) begin log_a[nlog] = reg_addr; log_d[nlog] = reg_wdata; end
                    nlog++;
                    case (reg_addr)
                        GCTRL: begin
                            if (reg_wdata[2] && !m_ctrl[2]) begin trn_on = 1; trn_t = cyc; end
                            if (!reg_wdata[2]) trn_on = 0;
                            m_ctrl = reg_wdata;
                        end
                        LC2: m_lc2 = reg_wdata;
                        CAP: m_cap = reg_wdata;
                        EQ:  m_eq  = reg_wdata;
                        RDC: m_rdc = reg_wdata;
                        WRC: m_wrc = reg_wdata;
                        default: ;
                    endcase
                end else begin
                    case (reg_addr)
                        GSTAT: begin
                            reg_rdata = status_val();
                            if (reg_rdata[1] && reg_rdata[9]) t_up = cyc;
                        end
                        GCTRL: reg_rdata = m_ctrl;
                        LC2:   reg_rdata = m_lc2;
                        CAP:   reg_rdata = m_cap;
                        EQ:    reg_rdata = m_eq;
                        default: reg_rdata = 32'hDEAD_BEEF;
                    endcase
                end
                reg_ack = 1;
            end else begin
                cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic setup(input int md, input logic [31:0] ctrl0);
        mode = md; m_ctrl = ctrl0; m_lc2 = 32'hA5A5_A5A5; m_cap = 32'h5A5A_5A5A;
        m_eq = 32'h1111_1111; m_rdc = 0; m_wrc = 0; trn_on = 0; trn_t = 0;
        t_up = -1; nlog = 0;
    endtask

    task automatic run(input logic [3:0] spd, output int t0, output int t1);
        int w;
        @(negedge clk); target_speed = spd; start = 1; t0 = cyc;
        @(negedge clk); start = 0;
        @(negedge clk);
        chk("R1 start clears done", {31'b0, done}, 32'd0);
        w = 0;
        while (!done && w < 5000) begin @(negedge clk); w++; end
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL R10 run did not finish: actual %h expected %h", done, 1'b1);
        end
        t1 = cyc;
    endtask

    task automatic chk_cfg(input logic [3:0] spd, input logic [31:0] ctrl0, input bit down0,
                           input bit reen);
        logic [15:0] ea [0:7];
        int n = 0;
        logic [31:0] ectl;
        if (down0) ea[n++] = GCTRL;
        ea[n++] = GCTRL; ea[n++] = RDC; ea[n++] = WRC; ea[n++] = LC2; ea[n++] = CAP; ea[n++] = EQ;
        if (reen) ea[n++] = GCTRL;
        chk("R8 write count", nlog, n);
        for (int i = 0; i < n && i < nlog; i++) chk("R8 write order", {16'b0, log_a[i]}, {16'b0, ea[i]});
        // R3: first write clears bit 2 only
        if (down0) chk("R3 training off", log_d[0], ctrl0 & ~32'h4);
        ectl = (ctrl0 & ~32'hF4) | 32'h40;
        if (reen || !down0 && ctrl0[2]) ectl = ectl | 32'h4;
        chk("R4 R9 global control", m_ctrl, ectl);
        chk("R5 read attr", m_rdc, 32'h0000_3511);
        chk("R5 write attr", m_wrc, 32'h0000_5311);
        chk("R6 link ctl2", m_lc2, 32'hA5A5_A5A0 | {28'b0, spd});
        chk("R6 link cap", m_cap, 32'h5A5A_5A50 | {28'b0, spd});
        chk("R7 eq ctrl", m_eq, 32'h1111_1131);
    endtask

    initial begin
        int t0, t1, d;
        setup(0, 32'h0);
        nacc = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset done", {31'b0, done}, 0);
        chk("R1 reset link_up", {31'b0, link_up}, 0);
        chk("R1 reset req", {31'b0, reg_req}, 0);

        for (int spd = 1; spd <= 3; spd++) begin
            for (int up = 0; up <= 1; up++) begin
                logic [31:0] c0;
                c0 = up ? 32'h1234_5A03 : 32'h1234_5A07;
                setup(up ? 0 : 1, c0);
                run(4'(spd), t0, t1);
                chk("R11 link up", {31'b0, link_up}, 1);
                chk_cfg(4'(spd), c0, !up, !up);
                d = t1 - t_up;
                compared++;
                if (t_up < 0 || d < STL_US * CPU || d > STL_US * CPU + 8) begin
                    mismatched++;
                    $display("FAIL R11 settle cycles: actual %0d expected %0d..%0d", d, STL_US*CPU, STL_US*CPU+8);
                end
                repeat (30) @(negedge clk);
                chk("R1 done held", {30'b0, done, link_up}, 32'd3);
            end
        end

        for (int md = 2; md <= 4; md++) begin
            setup(md, 32'h0000_0F04);
            run(4'd2, t0, t1);
            chk("R10 R2 link down", {30'b0, done, link_up}, 32'd2);
            chk_cfg(4'd2, 32'h0000_0F04, 1, 1);
            d = t1 - t0;
            compared++;
            if (d < TMO_US * CPU || d > TMO_US * CPU + 300) begin
                mismatched++;
                $display("FAIL R10 timeout cycles: actual %0d expected %0d..%0d", d, TMO_US*CPU, TMO_US*CPU+300);
            end
            repeat (20) @(negedge clk);
            chk("R1 down held", {30'b0, done, link_up}, 32'd2);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1500us;
        mismatched++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule